// File: doc/BRIEF.md
# Peripheral Sleep Gating Controller

This block decides, cycle by cycle, which peripheral clocks run and when the system may drop into a low-power state. Firmware writes a per-peripheral sleep-enable mask, arranged as five 32-bit groups, and a small sleep control register. Each peripheral drives a live clock-required flag. A peripheral's clock enable falls only when its sleep-enable bit is set and its own request flag is low. A peripheral that still wants its clock keeps it.

For system sleep, firmware selects light or heavy sleep and sets the sleep-all bit, then the CPU raises its sleep request. The controller first waits until every clock-required flag in all groups is clear and the PLL condition is met. It then enters the chosen sleep state, gates every peripheral clock and raises a light-sleep or heavy-sleep indication for the oscillator and clock tree. Dropping the CPU sleep request returns the controller to normal running on the next clock edge. The clock enables are synchronous enable levels meant to drive glitch-free gate cells outside this block.

Top module: `sleep_gate_ctrl`

## Requirements
- R1: After synchronous reset, all sleep-enable bits and the control register are 0, every clk_en bit is 1, and light_sleep and heavy_sleep are 0.
- R2: A write to address 0x30 + 4*g (g = 0..4) loads sleep-enable group g. Outside sleep, clk_en bit 32*g+b is 0 exactly when that enable bit is 1 and clk_req bit 32*g+b is 0. The new enable takes effect from the clock edge that samples the write.
- R3: A clk_en bit whose clk_req bit is 1 is always 1, in every state.
- R4: The control register at address 0x00 keeps only bit 0 (heavy select), bit 3 (sleep-all) and bit 8 (sleep allowed without PLL lock). Other data bits, and writes to addresses with no register, change nothing.
- R5: While sleep-all is 0, a CPU sleep request never raises light_sleep or heavy_sleep, and the clocks follow the per-bit rule of R2.
- R6: With sleep-all set, a CPU sleep request moves to a waiting state on the first edge. Sleep is entered no earlier than the second edge, and only on an edge where all 160 clk_req bits are 0. Clocks keep the R2 rule while waiting.
- R7: The sleep state entered is heavy when bit 0 is 1 and light when bit 0 is 0.
- R8: With bit 8 = 0, neither sleep state is entered while pll_locked is 0. With bit 8 = 1, heavy sleep may be entered without lock, but light sleep still needs lock.
- R9: In a sleep state every clk_en bit is 0, except bits whose clk_req is 1. These are re-enabled in the same cycle the request rises, and the sleep state is kept.
- R10: An edge that samples cpu_sleep_req = 0 returns the controller to running. light_sleep and heavy_sleep are then 0, and clk_en follows R2 again.
- R11: light_sleep and heavy_sleep are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| cpu_sleep_req | input | 1 | CPU is asking to sleep |
| pll_locked | input | 1 | PLL lock status |
| clk_req | input | 160 | Live clock-required flags, bit 32*g+b for group g bit b |
| clk_en | output | 160 | Per-peripheral clock enable |
| light_sleep | output | 1 | Light sleep state active |
| heavy_sleep | output | 1 | Heavy sleep state active |

## Verification
Register writes and the sleep state change on the clock edge that samples them. clk_en is combinational from that state and the live clk_req, so a change in a request shows in the same cycle and a write shows right after its edge. Sleep entry comes at the earliest two edges after the CPU request rises and one edge after the last request clears. Wake-up comes one edge after the request falls. The bench drives every input on the falling edge and samples a moment later, counting one rising edge per stage. It also checks the waiting cycle where no sleep indication may yet appear.

// File: rtl/sgc_pkg.sv
// Shared types and address constants for the sleep gating controller.
package sgc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_LIGHT = 2'd2,
        ST_HEAVY = 2'd3
    } sgc_state_e;

    localparam int CTRL_OFS   = 'h00;
    localparam int EN_BASE    = 'h30;
    localparam int EN_STRIDE  = 4;
    localparam int HEAVY_BIT  = 0;
    localparam int ALL_BIT    = 3;
    localparam int NOLOCK_BIT = 8;
endpackage

// File: rtl/sgc_regs.sv
// Register file: control bits and per-group sleep-enable masks.
// Assumes word-aligned addresses; unmatched addresses are ignored.
module sgc_regs
    import sgc_pkg::*;
#(
    parameter int NUM_GROUPS = 5,
    parameter int GROUP_W    = 32,
    parameter int ADDR_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [GROUP_W-1:0]            wr_data,
    output logic                          heavy_sel,
    output logic                          sleep_all,
    output logic                          nolock_ok,
    output logic [NUM_GROUPS*GROUP_W-1:0] sleep_en
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

    // Control register: only the three defined bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            heavy_sel <= 1'b0;
            sleep_all <= 1'b0;
            nolock_ok <= 1'b0;
        end else if (wr_en && wr_addr == CTRL_A) begin
            heavy_sel <= wr_data[HEAVY_BIT];
            sleep_all <= wr_data[ALL_BIT];
            nolock_ok <= wr_data[NOLOCK_BIT];
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_en
        localparam logic [ADDR_W-1:0] GA = ADDR_W'(EN_BASE + EN_STRIDE * g);
        logic [GROUP_W-1:0] en_q;
        // Sleep-enable group g, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q <= '0;
            else if (wr_en && wr_addr == GA)
                en_q <= wr_data;
        end
        assign sleep_en[g*GROUP_W +: GROUP_W] = en_q;
    end
endmodule

// File: rtl/sgc_fsm.sv
// System sleep sequencer: RUN -> WAIT -> LIGHT/HEAVY, back to RUN on wake.
// Assumes any_req is the OR of every live clock-required flag.
module sgc_fsm
    import sgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_sleep_req,
    input  logic sleep_all,
    input  logic heavy_sel,
    input  logic nolock_ok,
    input  logic pll_locked,
    input  logic any_req,
    output logic light_sleep,
    output logic heavy_sleep
);
    sgc_state_e state_q, state_d;
    logic       lock_ok;

    // PLL condition: lock always suffices; bit 8 waives it for heavy only.
    always_comb lock_ok = pll_locked || (heavy_sel && nolock_ok);

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        if (!cpu_sleep_req) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN:   if (sleep_all) state_d = ST_WAIT;
                ST_WAIT:  if (!any_req && lock_ok)
                              state_d = heavy_sel ? ST_HEAVY : ST_LIGHT;
                default:  state_d = state_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    assign light_sleep = (state_q == ST_LIGHT);
    assign heavy_sleep = (state_q == ST_HEAVY);
endmodule

// File: rtl/sgc_gate.sv
// Per-peripheral enable: off only when sleep is asked and no clock request.
// Assumes force_all is high in a system sleep state.
module sgc_gate #(
    parameter int NUM_GROUPS = 5,
    parameter int GROUP_W    = 32
) (
    input  logic [NUM_GROUPS*GROUP_W-1:0] sleep_en,
    input  logic [NUM_GROUPS*GROUP_W-1:0] clk_req,
    input  logic                          force_all,
    output logic [NUM_GROUPS*GROUP_W-1:0] clk_en
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GROUP_W-1:0] want_off;
        // Effective sleep request for this group.
        always_comb want_off = sleep_en[g*GROUP_W +: GROUP_W] | {GROUP_W{force_all}};
        assign clk_en[g*GROUP_W +: GROUP_W] = ~(want_off & ~clk_req[g*GROUP_W +: GROUP_W]);
    end
endmodule

// File: rtl/sleep_gate_ctrl.sv
// Top: peripheral clock gating and system sleep entry sequencing.
// Assumes clk_req flags are synchronous to clk.
module sleep_gate_ctrl #(
    parameter int NUM_GROUPS = 5,
    parameter int GROUP_W    = 32,
    parameter int ADDR_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [GROUP_W-1:0]            wr_data,
    input  logic                          cpu_sleep_req,
    input  logic                          pll_locked,
    input  logic [NUM_GROUPS*GROUP_W-1:0] clk_req,
    output logic [NUM_GROUPS*GROUP_W-1:0] clk_en,
    output logic                          light_sleep,
    output logic                          heavy_sleep
);
    localparam int NUM_PERIPH = NUM_GROUPS * GROUP_W;

    logic                  ctl_heavy, ctl_all, ctl_nolock;
    logic [NUM_PERIPH-1:0] sleep_en;
    logic                  any_req;

    // Any peripheral still wanting its clock blocks system sleep.
    always_comb any_req = |clk_req;

    sgc_regs #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .heavy_sel(ctl_heavy), .sleep_all(ctl_all), .nolock_ok(ctl_nolock),
        .sleep_en(sleep_en)
    );

    sgc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cpu_sleep_req(cpu_sleep_req),
        .sleep_all(ctl_all), .heavy_sel(ctl_heavy), .nolock_ok(ctl_nolock),
        .pll_locked(pll_locked), .any_req(any_req),
        .light_sleep(light_sleep), .heavy_sleep(heavy_sleep)
    );

    sgc_gate #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_gate (
        .sleep_en(sleep_en), .clk_req(clk_req),
        .force_all(light_sleep | heavy_sleep), .clk_en(clk_en)
    );
endmodule

// File: rtl/sgc_checker.sv
// Property checker for sleep_gate_ctrl, attached by bind.
module sgc_checker #(
    parameter int W = 160
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cpu_sleep_req,
    input logic         pll_locked,
    input logic         nolock_ok,
    input logic [W-1:0] clk_req,
    input logic [W-1:0] clk_en,
    input logic         light_sleep,
    input logic         heavy_sleep
);
    assert_req_keeps_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en & clk_req) == clk_req);

    assert_sleep_gates_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (light_sleep || heavy_sleep) |-> (clk_en == clk_req));

    assert_single_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({light_sleep, heavy_sleep}));

    assert_wake_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_sleep_req |=> !(light_sleep || heavy_sleep));

    assert_entry_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(light_sleep) || $rose(heavy_sleep)) |-> $past(clk_req == '0));

    assert_light_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(light_sleep) |-> $past(pll_locked));

    assert_heavy_lock_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(heavy_sleep) |-> $past(pll_locked || nolock_ok));
endmodule

bind sleep_gate_ctrl sgc_checker #(.W(NUM_GROUPS * GROUP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_sleep_req(cpu_sleep_req),
    .pll_locked(pll_locked), .nolock_ok(ctl_nolock), .clk_req(clk_req),
    .clk_en(clk_en), .light_sleep(light_sleep), .heavy_sleep(heavy_sleep)
);

// File: tb/sleep_gate_ctrl_test.sv
module sleep_gate_ctrl_test;
    localparam int G = 5;
    localparam int W = 32;
    localparam int N = G * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         cpu_sleep_req = 1'b0;
    logic         pll_locked = 1'b0;
    logic [N-1:0] clk_req = '0;
    logic [N-1:0] clk_en;
    logic         light_sleep, heavy_sleep;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] sh_en [G];

    always #10 clk = ~clk;

    sleep_gate_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_sleep_req(cpu_sleep_req), .pll_locked(pll_locked), .clk_req(clk_req),
        .clk_en(clk_en), .light_sleep(light_sleep), .heavy_sleep(heavy_sleep)
    );

    // Expected enables while running: gated only if enabled and not requested.
    function automatic logic [N-1:0] exp_run(input logic [N-1:0] req);
        logic [N-1:0] flat;
        for (int g = 0; g < G; g++) flat[g*W +: W] = sh_en[g];
        return ~(flat & ~req);
    endfunction

    task automatic chk_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: clk_en got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic rand_req();
        for (int g = 0; g < G; g++) clk_req[g*W +: W] = $urandom & $urandom;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int g = 0; g < G; g++) sh_en[g] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk_vec("R1 reset clk_en", clk_en, {N{1'b1}});
        chk_bit("R1 reset light", light_sleep, 1'b0);
        chk_bit("R1 reset heavy", heavy_sleep, 1'b0);

        // R2: directed group write
        wr(8'h38, 32'hFFFF_0000); sh_en[2] = 32'hFFFF_0000;
        chk_vec("R2 group2 gating", clk_en, exp_run(clk_req));
        // R3: request holds a gated-enabled clock
        clk_req[2*W + 20] = 1'b1; #1;
        chk_vec("R3 request keeps clock", clk_en, exp_run(clk_req));
        chk_bit("R3 bit 84", clk_en[2*W + 20], 1'b1);

        // R2/R3: random writes and request patterns
        for (int i = 0; i < 150; i++) begin
            int g;
            logic [31:0] d;
            g = $urandom % G;
            d = $urandom;
            wr(8'(8'h30 + 4 * g), d);
            sh_en[g] = d;
            rand_req(); #1;
            chk_vec("R2 R3 random gating", clk_en, exp_run(clk_req));
        end

        // R4: unmapped and misaligned writes change nothing
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h31, 32'hFFFF_FFFF);
        chk_vec("R4 unmapped writes ignored", clk_en, exp_run(clk_req));

        // R4/R5: undefined control bits ignored; sleep-all clear means no sleep
        wr(8'h00, 32'hFFFF_FEF6);
        pll_locked = 1'b1; clk_req = '0;
        cpu_sleep_req = 1'b1;
        idle(4);
        chk_bit("R4 R5 no light", light_sleep, 1'b0);
        chk_bit("R4 R5 no heavy", heavy_sleep, 1'b0);
        chk_vec("R5 run gating kept", clk_en, exp_run(clk_req));
        cpu_sleep_req = 1'b0;

        for (int g = 0; g < G; g++) begin
            wr(8'(8'h30 + 4 * g), 32'h0);
            sh_en[g] = '0;
        end
        wr(8'h34, 32'h00FF_00FF); sh_en[1] = 32'h00FF_00FF;

        // R6: light sleep waits for all requests to clear
        wr(8'h00, 32'h0000_0008);
        clk_req = '0; clk_req[100] = 1'b1;
        @(negedge clk); cpu_sleep_req = 1'b1;
        idle(3);
        chk_bit("R6 waits for requests", light_sleep, 1'b0);
        chk_vec("R6 clocks while waiting", clk_en, exp_run(clk_req));
        @(negedge clk); clk_req = '0;
        idle(1);
        chk_bit("R6 light entered", light_sleep, 1'b1);
        chk_bit("R7 light not heavy", heavy_sleep, 1'b0);
        chk_vec("R9 all gated in sleep", clk_en, {N{1'b0}});
        clk_req[7] = 1'b1; #1;
        chk_vec("R9 request re-enables", clk_en, {{(N-8){1'b0}}, 8'h80});
        chk_bit("R9 sleep kept", light_sleep, 1'b1);
        @(negedge clk); cpu_sleep_req = 1'b0;
        idle(1);
        chk_bit("R10 wake light", light_sleep, 1'b0);
        chk_vec("R10 clocks restored", clk_en, exp_run(clk_req));

        // R6: minimum two edges from request to sleep
        @(negedge clk); clk_req = '0; cpu_sleep_req = 1'b1;
        idle(1);
        chk_bit("R6 first edge waits", light_sleep, 1'b0);
        idle(1);
        chk_bit("R6 second edge sleeps", light_sleep, 1'b1);
        @(negedge clk); cpu_sleep_req = 1'b0;
        idle(1);

        // R7/R8: heavy needs lock when bit 8 is clear
        wr(8'h00, 32'h0000_0009);
        pll_locked = 1'b0;
        @(negedge clk); cpu_sleep_req = 1'b1;
        idle(4);
        chk_bit("R8 heavy blocked no lock", heavy_sleep, 1'b0);
        pll_locked = 1'b1;
        idle(1);
        chk_bit("R7 heavy entered", heavy_sleep, 1'b1);
        chk_bit("R11 not both", light_sleep & heavy_sleep, 1'b0);
        @(negedge clk); cpu_sleep_req = 1'b0;
        idle(1);
        chk_bit("R10 wake heavy", heavy_sleep, 1'b0);

        // R8: bit 8 waives lock for heavy only
        wr(8'h00, 32'h0000_0109);
        pll_locked = 1'b0;
        @(negedge clk); cpu_sleep_req = 1'b1;
        idle(2);
        chk_bit("R8 heavy without lock", heavy_sleep, 1'b1);
        @(negedge clk); cpu_sleep_req = 1'b0;
        idle(1);
        wr(8'h00, 32'h0000_0108);
        @(negedge clk); cpu_sleep_req = 1'b1;
        idle(4);
        chk_bit("R8 light still needs lock", light_sleep, 1'b0);
        pll_locked = 1'b1;
        idle(1);
        chk_bit("R8 light after lock", light_sleep, 1'b1);
        chk_bit("R11 single state", light_sleep & heavy_sleep, 1'b0);
        @(negedge clk); cpu_sleep_req = 1'b0;
        idle(1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule